// File: doc/BRIEF.md
# Single-Command Slow-Control Register Front End

This block sits between a host bus and a two-bit-wide serial control link. The host sees a small register slave clocked by the bus clock. It loads a 64-bit command into two payload words and then sets a go bit. The block carries the command into the link's transmit clock domain and sends it as a frame. When a reply frame arrives in the separate receive clock domain, the block carries it back to the bus domain, latches it and sets a receive flag. The flag can raise an interrupt.

Only one command may be in flight at any time. The go bit stays set, and status shows the block as busy, until the transmit side has taken the command. Both crossings use a toggle request with a toggle acknowledge. The multi-bit payload being crossed is held still until the far side confirms that it has taken it. An enable register gates the whole link. While it is 0, go requests do nothing and the transmitter sends only idle symbols.

On the wire, idle is symbol 2'b00. A frame is the start symbol 2'b11 followed by 32 payload symbols. The payload goes out most significant bits first, high word first, with one symbol per link clock. The receiver uses the same frame format.

Top module: `scp_top`

## Requirements
- R1: After reset, control, status, enable and both receive words read as 0, the interrupt is low and the link sends idle (2'b00).
- R2: The register map uses byte offsets: 0x00 is control (bit0 go, bit1 interrupt enable), 0x04 is status (bit0 busy, bit1 receive, bit2 overrun), 0x08 and 0x0C are the high and low data words, and 0x18 is the enable (bit0). Any other offset reads as 0.
- R3: The read-valid output is high exactly in the bus clock cycle after a cycle with the read strobe, and low otherwise.
- R4: Writing 1 to go while enabled and idle sets busy at once and sends one frame on the link: 2'b11, then the 64-bit payload {high, low} two bits per link clock, MSB first.
- R5: The go bit (control bit0) and busy clear by themselves once the link has accepted the command.
- R6: Writing go while a command is pending launches nothing and sets the sticky overrun bit. The bit stays set until 1 is written to status bit2.
- R7: A received frame (2'b11 plus 32 symbols) sets the receive bit. Reads of 0x08 and 0x0C then return that reply, never the transmit payload.
- R8: Writing 1 to status bit1 clears the receive bit. Writing 0 there leaves it unchanged.
- R9: The interrupt is high exactly while the receive bit and the interrupt-enable bit are both 1.
- R10: While enable is 0, a go write sets neither busy nor overrun and the link stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| mmAddr | input | 16 | Byte address |
| mmWrite | input | 1 | Write strobe |
| mmWdata | input | 32 | Write data |
| mmRead | input | 1 | Read strobe |
| mmRdata | output | 32 | Read data, valid with mmRvalid |
| mmRvalid | output | 1 | Read data valid |
| mmIrq | output | 1 | Interrupt to host |
| txClk | input | 1 | Link transmit clock |
| txData | output | 2 | Link transmit symbols |
| rxClk | input | 1 | Link receive clock |
| rxData | input | 2 | Link receive symbols |

## Verification
The bench issues two go writes in consecutive cycles. A design that failed to block the second would send two frames or lose the overrun flag. It checks that payload reads return the reply and not the words just written; a design with a shared register would echo the transmit payload. Clearing the receive bit is tested by writing 0 and then 1 to it, to catch a design that clears on any write or never clears, and the interrupt is compared with both enable states. Go is also written with the link disabled, and both frame contents and idle periods are watched on the serial output.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam logic [1:0] SYM_IDLE  = 2'b00;
  localparam logic [1:0] SYM_START = 2'b11;

  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 4;
  localparam int OFF_HI   = 8;
  localparam int OFF_LO   = 12;
  localparam int OFF_EN   = 24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_HI, SEL_LO, SEL_EN
  } regSel_e;

  typedef struct packed {
    logic    wrHi;
    logic    wrLo;
    logic    launch;
    logic    capRx;
    logic    rdEn;
    regSel_e rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] address,
  input  logic              write,
  input  logic [2:0]        wbits,
  input  logic              read,
  input  logic              ackTgl,
  input  logic              rxTgl,
  output logic              reqTgl,
  output logic              rxAckTgl,
  output dpStrobe_t         strb,
  output logic [7:0]        ctrlByte,
  output logic [7:0]        statByte,
  output logic              enBit,
  output logic              irq
);
  logic [1:0] ackSync, rxSync;
  logic ackSeen, rxSeen;
  logic busy, rcv, ovr, irqEn, enReg;
  logic ackEdge, rxEdge;
  logic hitCtrl, hitStat, hitHi, hitLo, hitEn;
  logic goReq, launch;

  assign hitCtrl = address == ADDR_W'(OFF_CTRL);
  assign hitStat = address == ADDR_W'(OFF_STAT);
  assign hitHi   = address == ADDR_W'(OFF_HI);
  assign hitLo   = address == ADDR_W'(OFF_LO);
  assign hitEn   = address == ADDR_W'(OFF_EN);

  assign ackEdge = ackSync[1] ^ ackSeen;
  assign rxEdge  = rxSync[1] ^ rxSeen;
  assign goReq   = write && hitCtrl && wbits[0] && enReg;
  assign launch  = goReq && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSync  <= '0;
      rxSync   <= '0;
      ackSeen  <= 1'b0;
      rxSeen   <= 1'b0;
      busy     <= 1'b0;
      rcv      <= 1'b0;
      ovr      <= 1'b0;
      irqEn    <= 1'b0;
      enReg    <= 1'b0;
      reqTgl   <= 1'b0;
      rxAckTgl <= 1'b0;
    end else begin
      ackSync <= {ackSync[0], ackTgl};
      rxSync  <= {rxSync[0], rxTgl};
      ackSeen <= ackSync[1];
      rxSeen  <= rxSync[1];

      if (launch) begin
        busy   <= 1'b1;
        reqTgl <= ~reqTgl;
      end else if (ackEdge) begin
        busy <= 1'b0;
      end

      if (goReq && busy)                   ovr <= 1'b1;
      else if (write && hitStat && wbits[2]) ovr <= 1'b0;

      if (rxEdge) begin
        rcv      <= 1'b1;
        rxAckTgl <= ~rxAckTgl;
      end else if (write && hitStat && wbits[1]) begin
        rcv <= 1'b0;
      end

      if (write && hitCtrl) irqEn <= wbits[1];
      if (write && hitEn)   enReg <= wbits[0];
    end
  end

  always_comb begin
    strb.wrHi   = write && hitHi;
    strb.wrLo   = write && hitLo;
    strb.launch = launch;
    strb.capRx  = rxEdge;
    strb.rdEn   = read;
    if (hitCtrl)     strb.rdSel = SEL_CTRL;
    else if (hitStat) strb.rdSel = SEL_STAT;
    else if (hitHi)   strb.rdSel = SEL_HI;
    else if (hitLo)   strb.rdSel = SEL_LO;
    else if (hitEn)   strb.rdSel = SEL_EN;
    else              strb.rdSel = SEL_NONE;
  end

  assign ctrlByte = {6'b0, irqEn, busy};
  assign statByte = {5'b0, ovr, rcv, busy};
  assign enBit    = enReg;
  assign irq      = rcv & irqEn;
endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PAY_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAY_W-1:0]  rxHold,
  input  logic [7:0]        ctrlByte,
  input  logic [7:0]        statByte,
  input  logic              enBit,
  output logic [PAY_W-1:0]  launchWord,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] txHi, txLo;
  logic [PAY_W-1:0]  rxWord;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL: rdMux = DATA_W'(ctrlByte);
      SEL_STAT: rdMux = DATA_W'(statByte);
      SEL_HI:   rdMux = rxWord[PAY_W-1:DATA_W];
      SEL_LO:   rdMux = rxWord[DATA_W-1:0];
      SEL_EN:   rdMux = DATA_W'(enBit);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHi       <= '0;
      txLo       <= '0;
      rxWord     <= '0;
      launchWord <= '0;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      if (strb.wrHi)   txHi       <= wdata;
      if (strb.wrLo)   txLo       <= wdata;
      if (strb.launch) launchWord <= {txHi, txLo};
      if (strb.capRx)  rxWord     <= rxHold;
      rvalid <= strb.rdEn;
      rdata  <= strb.rdEn ? rdMux : '0;
    end
  end
endmodule

// File: rtl/scp_txlink.sv
module scp_txlink
  import scp_pkg::*;
#(
  parameter int PAY_W = 64,
  localparam int SYM_W = 2,
  localparam int NSYM  = PAY_W / SYM_W,
  localparam int CNT_W = $clog2(NSYM + 1)
) (
  input  logic             txClk,
  input  logic             rstN,
  input  logic             enIn,
  input  logic             reqTgl,
  input  logic [PAY_W-1:0] launchWord,
  output logic             ackTgl,
  output logic [SYM_W-1:0] txData
);
  localparam logic [CNT_W-1:0] NSYM_C = CNT_W'(NSYM);

  logic [1:0]       enSync, reqSync;
  logic             reqSeen, active;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] shift;

  always_ff @(posedge txClk or negedge rstN) begin
    if (!rstN) begin
      enSync  <= '0;
      reqSync <= '0;
      reqSeen <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      shift   <= '0;
      ackTgl  <= 1'b0;
      txData  <= SYM_IDLE;
    end else begin
      enSync  <= {enSync[0], enIn};
      reqSync <= {reqSync[0], reqTgl};
      if (active) begin
        if (!enSync[1] || cnt == '0) begin
          active <= 1'b0;
          txData <= SYM_IDLE;
        end else begin
          txData <= shift[PAY_W-1 -: SYM_W];
          shift  <= shift << SYM_W;
          cnt    <= cnt - 1'b1;
        end
      end else if (reqSync[1] != reqSeen) begin
        reqSeen <= reqSync[1];
        ackTgl  <= ~ackTgl;
        if (enSync[1]) begin
          shift  <= launchWord;
          cnt    <= NSYM_C;
          active <= 1'b1;
          txData <= SYM_START;
        end else begin
          txData <= SYM_IDLE;
        end
      end else begin
        txData <= SYM_IDLE;
      end
    end
  end
endmodule

// File: rtl/scp_rxlink.sv
module scp_rxlink
  import scp_pkg::*;
#(
  parameter int PAY_W = 64,
  localparam int SYM_W = 2,
  localparam int NSYM  = PAY_W / SYM_W,
  localparam int CNT_W = $clog2(NSYM + 1)
) (
  input  logic             rxClk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] rxData,
  input  logic             rxAckTgl,
  output logic             rxTgl,
  output logic [PAY_W-1:0] rxHold
);
  localparam logic [CNT_W-1:0] NSYM_C = CNT_W'(NSYM);

  logic [1:0]       ackSync;
  logic             inFrame;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] shreg;
  logic [PAY_W-1:0] nextWord;

  assign nextWord = {shreg[PAY_W-SYM_W-1:0], rxData};

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      ackSync <= '0;
      inFrame <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      rxTgl   <= 1'b0;
      rxHold  <= '0;
    end else begin
      ackSync <= {ackSync[0], rxAckTgl};
      if (!inFrame) begin
        if (rxData == SYM_START) begin
          inFrame <= 1'b1;
          cnt     <= NSYM_C;
        end
      end else begin
        shreg <= nextWord;
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          inFrame <= 1'b0;
          if (rxTgl == ackSync[1]) begin
            rxHold <= nextWord;
            rxTgl  <= ~rxTgl;
          end
        end
      end
    end
  end
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PAY_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] mmAddr,
  input  logic              mmWrite,
  input  logic [DATA_W-1:0] mmWdata,
  input  logic              mmRead,
  output logic [DATA_W-1:0] mmRdata,
  output logic              mmRvalid,
  output logic              mmIrq,
  input  logic              txClk,
  output logic [1:0]        txData,
  input  logic              rxClk,
  input  logic [1:0]        rxData
);
  dpStrobe_t        strb;
  logic [7:0]       ctrlByte, statByte;
  logic             enBit, reqTgl, ackTgl, rxTgl, rxAckTgl;
  logic [PAY_W-1:0] launchWord, rxHold;

  scp_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .address(mmAddr), .write(mmWrite),
    .wbits(mmWdata[2:0]), .read(mmRead), .ackTgl(ackTgl), .rxTgl(rxTgl),
    .reqTgl(reqTgl), .rxAckTgl(rxAckTgl), .strb(strb), .ctrlByte(ctrlByte),
    .statByte(statByte), .enBit(enBit), .irq(mmIrq)
  );

  scp_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(mmWdata), .rxHold(rxHold),
    .ctrlByte(ctrlByte), .statByte(statByte), .enBit(enBit),
    .launchWord(launchWord), .rdata(mmRdata), .rvalid(mmRvalid)
  );

  scp_txlink #(.PAY_W(PAY_W)) tx_i (
    .txClk(txClk), .rstN(rstN), .enIn(enBit), .reqTgl(reqTgl),
    .launchWord(launchWord), .ackTgl(ackTgl), .txData(txData)
  );

  scp_rxlink #(.PAY_W(PAY_W)) rx_i (
    .rxClk(rxClk), .rstN(rstN), .rxData(rxData), .rxAckTgl(rxAckTgl),
    .rxTgl(rxTgl), .rxHold(rxHold)
  );
endmodule

// File: rtl/scp_chk.sv
module scp_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] mmAddr,
  input logic        mmWrite,
  input logic [2:0]  wbits,
  input logic        mmRead,
  input logic        mmRvalid,
  input logic        mmIrq,
  input logic [7:0]  statByte,
  input logic        enBit,
  input logic        capRx
);
  logic wrStat;
  assign wrStat = mmWrite && (mmAddr == 16'd4);

  // R3
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmRead |=> mmRvalid);
  // R3
  rvalid_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mmRead |=> !mmRvalid);
  // R10
  launch_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statByte[0]) |-> $past(enBit));
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[2] && !(wrStat && wbits[2])) |=> statByte[2]);
  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statByte[2]) |-> $past(statByte[0]));
  // R8
  rcv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[1] && !(wrStat && wbits[1])) |=> statByte[1]);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wbits[1] && !capRx) |=> !mmIrq);
endmodule

bind scp_top scp_chk chk_i (
  .clk(clk), .rstN(rstN), .mmAddr(mmAddr), .mmWrite(mmWrite),
  .wbits(mmWdata[2:0]), .mmRead(mmRead), .mmRvalid(mmRvalid), .mmIrq(mmIrq),
  .statByte(statByte), .enBit(enBit), .capRx(strb.capRx)
);

// File: tb/scp_top_tb_top.sv
module scp_top_tb_top;
  logic        clk = 0, txClk = 0, rxClk = 0, rstN = 0;
  logic [15:0] mmAddr = '0;
  logic        mmWrite = 0, mmRead = 0;
  logic [31:0] mmWdata = '0;
  logic [31:0] mmRdata;
  logic        mmRvalid, mmIrq;
  logic [1:0]  txData;
  logic [1:0]  rxData = 2'b00;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5  clk   = ~clk;
  always #12.5 txClk = ~txClk;
  always #17.5 rxClk = ~rxClk;

  scp_top dut_i (
    .clk(clk), .rstN(rstN), .mmAddr(mmAddr), .mmWrite(mmWrite),
    .mmWdata(mmWdata), .mmRead(mmRead), .mmRdata(mmRdata),
    .mmRvalid(mmRvalid), .mmIrq(mmIrq), .txClk(txClk), .txData(txData),
    .rxClk(rxClk), .rxData(rxData)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R3 reference: read-valid mirrors the read strobe one clock later
  logic lastRd = 0;
  always @(posedge clk) lastRd <= mmRead;
  always @(negedge clk) if (rstN && !done) check("R3 rvalid", 64'(mmRvalid), 64'(lastRd));

  // link transmit monitor: queue of decoded frames and idle-violation count
  logic [63:0] txFrames[$];
  int txActive = 0;
  int monState = 0, monCnt = 0;
  logic [63:0] monWord;
  always @(negedge txClk) begin
    if (txData != 2'b00) txActive++;
    if (monState == 0) begin
      if (txData == 2'b11) begin monState = 1; monCnt = 0; monWord = '0; end
    end else begin
      monWord = {monWord[61:0], txData};
      monCnt++;
      if (monCnt == 32) begin txFrames.push_back(monWord); monState = 0; end
    end
  end

  task automatic busWrite(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    mmAddr = a; mmWdata = d; mmWrite = 1;
    @(negedge clk);
    mmWrite = 0;
  endtask

  task automatic busRead(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    mmAddr = a; mmRead = 1;
    @(negedge clk);
    mmRead = 0;
    d = mmRdata;
  endtask

  task automatic readCheck(string req, logic [15:0] a, logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, 64'(d), 64'(exp));
  endtask

  task automatic waitStatus(string req, logic [31:0] mask, logic [31:0] val);
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      busRead(16'h4, d);
      if ((d & mask) == val) break;
    end
    check(req, 64'(d & mask), 64'(val));
  endtask

  task automatic sendReply(logic [63:0] w);
    @(negedge rxClk); rxData = 2'b11;
    for (int i = 31; i >= 0; i--) begin
      @(negedge rxClk); rxData = w[2*i +: 2];
    end
    @(negedge rxClk); rxData = 2'b00;
  endtask

  task automatic waitFrames(int n);
    for (int i = 0; i < 400 && txFrames.size() < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    readCheck("R1 ctrl", 16'h0, 32'h0);
    readCheck("R1 status", 16'h4, 32'h0);
    readCheck("R1 enable", 16'h18, 32'h0);
    readCheck("R1 rx hi", 16'h8, 32'h0);
    check("R1 irq", 64'(mmIrq), 64'h0);
    check("R1 tx idle", 64'(txData), 64'h0);

    // R2 unmapped offsets and enable read back
    readCheck("R2 unmapped 0x10", 16'h10, 32'h0);
    readCheck("R2 unmapped 0x100", 16'h100, 32'h0);
    busWrite(16'h18, 32'h1);
    readCheck("R2 enable", 16'h18, 32'h1);

    // R4 launch
    busWrite(16'h8, 32'hA5A5_1234);
    busWrite(16'hC, 32'h0F0F_CAFE);
    readCheck("R7 rx hi not tx", 16'h8, 32'h0);
    busWrite(16'h0, 32'h1);
    readCheck("R4 busy", 16'h4, 32'h1);
    waitStatus("R5 busy clears", 32'h1, 32'h0);
    readCheck("R5 go clears", 16'h0, 32'h0);
    waitFrames(1);
    check("R4 frame count", 64'(txFrames.size()), 64'd1);
    if (txFrames.size() > 0) check("R4 frame", txFrames.pop_front(), 64'hA5A5_1234_0F0F_CAFE);

    // R6 back-to-back go
    busWrite(16'h8, 32'h1357_9BDF);
    busWrite(16'hC, 32'h2468_ACE0);
    busWrite(16'h0, 32'h1);
    busWrite(16'h0, 32'h1);
    readCheck("R6 busy+overrun", 16'h4, 32'h5);
    waitStatus("R6 busy clears", 32'h1, 32'h0);
    waitFrames(1);
    repeat (300) @(negedge clk);
    check("R6 single frame", 64'(txFrames.size()), 64'd1);
    if (txFrames.size() > 0) check("R4 frame2", txFrames.pop_front(), 64'h1357_9BDF_2468_ACE0);
    readCheck("R6 sticky", 16'h4, 32'h4);
    busWrite(16'h4, 32'h4);
    readCheck("R6 cleared", 16'h4, 32'h0);

    // R7 reply with interrupt disabled
    sendReply(64'hDEAD_BEEF_0123_4567);
    waitStatus("R7 rcv set", 32'h2, 32'h2);
    check("R9 irq off", 64'(mmIrq), 64'h0);
    readCheck("R7 hi", 16'h8, 32'hDEAD_BEEF);
    readCheck("R7 lo", 16'hC, 32'h0123_4567);
    busWrite(16'h0, 32'h2);
    @(negedge clk);
    check("R9 irq on", 64'(mmIrq), 64'h1);
    busWrite(16'h4, 32'h0);
    readCheck("R8 write0 keeps", 16'h4, 32'h2);
    busWrite(16'h4, 32'h2);
    readCheck("R8 w1c", 16'h4, 32'h0);
    check("R9 irq low", 64'(mmIrq), 64'h0);

    // R9 second reply with interrupt enabled
    sendReply(64'hFFFF_0000_8000_0001);
    waitStatus("R7 rcv set 2", 32'h2, 32'h2);
    check("R9 irq rises", 64'(mmIrq), 64'h1);
    readCheck("R7 hi 2", 16'h8, 32'hFFFF_0000);
    readCheck("R7 lo 2", 16'hC, 32'h8000_0001);
    busWrite(16'h4, 32'h2);

    // R10 disabled link
    busWrite(16'h18, 32'h0);
    repeat (20) @(negedge clk);
    base = txActive;
    busWrite(16'h0, 32'h3);
    readCheck("R10 no busy", 16'h4, 32'h0);
    repeat (300) @(negedge clk);
    check("R10 tx idle", 64'(txActive - base), 64'd0);
    check("R10 no frame", 64'(txFrames.size()), 64'd0);
    readCheck("R10 status", 16'h4, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule